// File: doc/BRIEF.md
# Pipelined Bus Phase-Rule Monitor

This block watches the manager and subordinate signals of a pipelined, single-transfer system bus and never drives the bus itself. It follows which transfer owns the data phase and what the bus looked like in the previous cycle. While a stall is in progress it checks that whatever the stall is holding stays unchanged. It also flags transfer-type codes that a single-transfer bus must not carry, and wait states that are inserted when no transfer is outstanding.

Each kind of violation sets its own bit in a sticky error vector. A bit stays set until the clear input is pulsed or the block is reset. Two counters record completed reads and completed writes, so a surrounding testbench can compare its own transfer tally against them. An integrator connects the block in parallel with the bus signals and polls or probes the error vector.

Top module: `bus_phase_monitor`

## Requirements
- R1: A data phase opens when the transfer code is NONSEQ (2'b10) in a cycle with `mon_ready` high. It completes in the first later cycle with `mon_ready` high. If `mon_resp` is low (OKAY) in that cycle, `rd_done_cnt` (for a read) or `wr_done_cnt` (for a write) goes up by one at that clock edge, and the counters wrap around at their width.
- R2: A data phase whose closing cycle has `mon_resp` high is not counted. A cycle with `mon_ready` low completes nothing and leaves the direction of the pending data phase unchanged.
- R3: Bit 0 of `err_flags` is the address/control hold error. It sets when the previous cycle had `mon_ready` low with a NONSEQ code, and the current `mon_addr`, `mon_size` or `mon_trans` differs from that previous cycle.
- R4: Bit 1 of `err_flags` is the direction hold error. It sets under the same held-address condition as R3 when `mon_write` differs from its value in the previous cycle.
- R5: Bit 2 of `err_flags` is the write-data hold error. It sets when the previous cycle had `mon_ready` low, the active data phase is a write, and `mon_wdata` has changed. During a stalled read data phase, changes on `mon_wdata` set no bit.
- R6: Bit 3 of `err_flags` is the illegal transfer-type error. It sets in any cycle where `mon_trans` is BUSY (2'b01) or SEQ (2'b11).
- R7: Bit 4 of `err_flags` is the spurious-wait error. It sets when `mon_ready` is low while no data phase is active.
- R8: A violation is visible on `err_flags` after the clock edge that ends the offending cycle, and the bit then stays set. Asserting `err_clr` clears every bit at the next edge, except a bit whose violation occurs in that same cycle, which stays set.
- R9: While `rst_n` is low at a clock edge, `err_flags`, both counters and the phase state return to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_clr | input | 1 | Clears the sticky error vector |
| mon_trans | input | 2 | Transfer type code (IDLE 00, BUSY 01, NONSEQ 10, SEQ 11) |
| mon_addr | input | ADDR_W | Address of the current address phase |
| mon_write | input | 1 | Direction: 1 write, 0 read |
| mon_size | input | 3 | Transfer size code |
| mon_wdata | input | DATA_W | Write data bus |
| mon_ready | input | 1 | Subordinate ready; low inserts a wait state |
| mon_resp | input | 1 | Subordinate response: 0 OKAY, 1 error |
| err_flags | output | 5 | Sticky violation bits, indexed as in R3 to R7 |
| rd_done_cnt | output | CNT_W | Completed OKAY reads |
| wr_done_cnt | output | CNT_W | Completed OKAY writes |

## Verification
The clear request and a fresh violation can arrive in the same cycle. The bench provokes this by holding `err_clr` high in a cycle where the subordinate drives ready low with no transfer outstanding. It then expects bit 4 to survive the clear while all other bits drop. A second collision also occurs: a write completes in the same cycle that both the direction hold rule and the write-data hold rule are broken. There the bench expects the write counter to advance and bits 1 and 2 to set on the same edge.

// File: rtl/bpm_pkg.sv
// Package: shared codes and error-bit indices for the bus phase monitor.
// Assumes a single-transfer bus; burst codes are treated as violations.
package bpm_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    localparam int ERR_CTRL_HOLD  = 0;
    localparam int ERR_DIR_HOLD   = 1;
    localparam int ERR_WDATA_HOLD = 2;
    localparam int ERR_BAD_TYPE   = 3;
    localparam int ERR_IDLE_WAIT  = 4;
    localparam int N_ERR          = 5;

endpackage

// File: rtl/bpm_phase_tracker.sv
// Module: bpm_phase_tracker
// Follows which transfer owns the data phase and keeps a one-cycle
// snapshot of the bus so that hold rules can compare cycle to cycle.
// Assumes mon_ready is the globally observed ready of the selected slave.
module bpm_phase_tracker
    import bpm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        trans,
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic [2:0]        size,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ready,
    output logic              dp_valid,
    output logic              dp_write,
    output logic              stall_q,
    output logic              pend_q,
    output logic [1:0]        trans_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic              write_q,
    output logic [2:0]        size_q,
    output logic [DATA_W-1:0] wdata_q
);

    logic start_xfer;
    assign start_xfer = (trans == TR_NONSEQ);

    // Data-phase owner: advances only when the bus is not stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_valid <= 1'b0;
            dp_write <= 1'b0;
        end else if (ready) begin
            dp_valid <= start_xfer;
            dp_write <= start_xfer & write;
        end
    end

    // Previous-cycle snapshot of the bus used by the hold rules.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_q <= 1'b0;
            pend_q  <= 1'b0;
            trans_q <= '0;
            addr_q  <= '0;
            write_q <= 1'b0;
            size_q  <= '0;
            wdata_q <= '0;
        end else begin
            stall_q <= ~ready;
            pend_q  <= start_xfer;
            trans_q <= trans;
            addr_q  <= addr;
            write_q <= write;
            size_q  <= size;
            wdata_q <= wdata;
        end
    end

    // A stalled cycle must not move the data phase on (R2).
    assert_stall_holds_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ($stable(dp_valid) && $stable(dp_write)));

    // A completed cycle with NONSEQ opens a data phase (R1).
    assert_nonseq_opens_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && trans == TR_NONSEQ) |=> dp_valid);

endmodule

// File: rtl/bpm_rule_checks.sv
// Module: bpm_rule_checks
// Combinational rule evaluation: compares the live bus against the
// previous-cycle snapshot and the data-phase owner, one bit per rule.
// Assumes the snapshot comes from bpm_phase_tracker.
module bpm_rule_checks
    import bpm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic [1:0]        trans,
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic [2:0]        size,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ready,
    input  logic              dp_valid,
    input  logic              dp_write,
    input  logic              stall_q,
    input  logic              pend_q,
    input  logic [1:0]        trans_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic              write_q,
    input  logic [2:0]        size_q,
    input  logic [DATA_W-1:0] wdata_q,
    output logic [N_ERR-1:0]  viol
);

    logic held_addr;
    logic ctrl_moved;

    // A pending address is frozen when the previous cycle stalled it.
    always_comb begin
        held_addr  = stall_q & pend_q;
        ctrl_moved = (addr != addr_q) | (size != size_q) | (trans != trans_q);
    end

    // One violation bit per rule.
    always_comb begin
        viol                 = '0;
        viol[ERR_CTRL_HOLD]  = held_addr & ctrl_moved;
        viol[ERR_DIR_HOLD]   = held_addr & (write != write_q);
        viol[ERR_WDATA_HOLD] = stall_q & dp_valid & dp_write & (wdata != wdata_q);
        viol[ERR_BAD_TYPE]   = (trans == TR_BUSY) | (trans == TR_SEQ);
        viol[ERR_IDLE_WAIT]  = ~ready & ~dp_valid;
    end

endmodule

// File: rtl/bpm_sticky_flags.sv
// Module: bpm_sticky_flags
// Sticky error vector: each bit sets on its violation and is cleared
// by the clear input; a same-cycle violation wins over the clear.
module bpm_sticky_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] set,
    output logic [N-1:0] flags
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Per-bit set-dominant sticky register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (set[i])
                flags[i] <= 1'b1;
            else if (clr)
                flags[i] <= 1'b0;
        end

        assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !clr) |=> flags[i]);

        assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && !set[i]) |=> !flags[i]);
    end

    assert_flags_reset_R9: assert property (@(posedge clk)
        !rst_n |=> (flags == '0));

endmodule

// File: rtl/bpm_xfer_counter.sv
// Module: bpm_xfer_counter
// Counts completed OKAY reads and writes; wraps at its width.
// Assumes dp_valid/dp_write describe the transfer in its data phase.
module bpm_xfer_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dp_valid,
    input  logic             dp_write,
    input  logic             ready,
    input  logic             resp,
    output logic [CNT_W-1:0] rd_cnt,
    output logic [CNT_W-1:0] wr_cnt
);

    logic done_ok;
    assign done_ok = dp_valid & ready & ~resp;

    // Increment the counter matching the completing direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt <= '0;
            wr_cnt <= '0;
        end else if (done_ok) begin
            if (dp_write)
                wr_cnt <= wr_cnt + 1'b1;
            else
                rd_cnt <= rd_cnt + 1'b1;
        end
    end

    assert_no_count_in_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ($stable(rd_cnt) && $stable(wr_cnt)));

    assert_no_count_on_error_R2: assert property (@(posedge clk) disable iff (!rst_n)
        resp |=> ($stable(rd_cnt) && $stable(wr_cnt)));

    assert_read_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ok && !dp_write) |=> (rd_cnt == $past(rd_cnt) + 1'b1) && $stable(wr_cnt));

    assert_counts_reset_R9: assert property (@(posedge clk)
        !rst_n |=> (rd_cnt == '0 && wr_cnt == '0));

endmodule

// File: rtl/bus_phase_monitor.sv
// Module: bus_phase_monitor (top)
// Passive checker for a pipelined single-transfer bus. Tracks phases,
// evaluates hold and type rules, keeps sticky flags and transfer counts.
// Assumes it observes the bus at the same clock as the subordinate.
module bus_phase_monitor
    import bpm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_clr,
    input  logic [1:0]        mon_trans,
    input  logic [ADDR_W-1:0] mon_addr,
    input  logic              mon_write,
    input  logic [2:0]        mon_size,
    input  logic [DATA_W-1:0] mon_wdata,
    input  logic              mon_ready,
    input  logic              mon_resp,
    output logic [N_ERR-1:0]  err_flags,
    output logic [CNT_W-1:0]  rd_done_cnt,
    output logic [CNT_W-1:0]  wr_done_cnt
);

    logic              dp_valid;
    logic              dp_write;
    logic              stall_q;
    logic              pend_q;
    logic [1:0]        trans_q;
    logic [ADDR_W-1:0] addr_q;
    logic              write_q;
    logic [2:0]        size_q;
    logic [DATA_W-1:0] wdata_q;
    logic [N_ERR-1:0]  viol;

    bpm_phase_tracker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .trans   (mon_trans),
        .addr    (mon_addr),
        .write   (mon_write),
        .size    (mon_size),
        .wdata   (mon_wdata),
        .ready   (mon_ready),
        .dp_valid(dp_valid),
        .dp_write(dp_write),
        .stall_q (stall_q),
        .pend_q  (pend_q),
        .trans_q (trans_q),
        .addr_q  (addr_q),
        .write_q (write_q),
        .size_q  (size_q),
        .wdata_q (wdata_q)
    );

    bpm_rule_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rules (
        .trans   (mon_trans),
        .addr    (mon_addr),
        .write   (mon_write),
        .size    (mon_size),
        .wdata   (mon_wdata),
        .ready   (mon_ready),
        .dp_valid(dp_valid),
        .dp_write(dp_write),
        .stall_q (stall_q),
        .pend_q  (pend_q),
        .trans_q (trans_q),
        .addr_q  (addr_q),
        .write_q (write_q),
        .size_q  (size_q),
        .wdata_q (wdata_q),
        .viol    (viol)
    );

    bpm_sticky_flags #(.N(N_ERR)) u_flags (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (err_clr),
        .set  (viol),
        .flags(err_flags)
    );

    bpm_xfer_counter #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .dp_valid(dp_valid),
        .dp_write(dp_write),
        .ready   (mon_ready),
        .resp    (mon_resp),
        .rd_cnt  (rd_done_cnt),
        .wr_cnt  (wr_done_cnt)
    );

    // A BUSY or SEQ code on the port must show up as a flag (R6).
    assert_bad_type_flagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_trans == TR_BUSY || mon_trans == TR_SEQ) |=> err_flags[ERR_BAD_TYPE]);

    // A wait with no outstanding transfer must raise the flag (R7).
    assert_idle_wait_flagged_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mon_ready && !dp_valid) |=> err_flags[ERR_IDLE_WAIT]);

endmodule

// File: tb/bus_phase_monitor_tb.sv
`timescale 1ns/1ps
module bus_phase_monitor_tb;

    typedef struct packed {
        logic        clr;
        logic [1:0]  tr;
        logic [31:0] addr;
        logic        wr;
        logic [2:0]  sz;
        logic [31:0] wd;
        logic        rdy;
        logic        rsp;
        logic [4:0]  e;
        logic [7:0]  r;
        logic [7:0]  w;
    } vec_t;

    localparam int NV = 32;
    // Fields: clr, trans, addr, write, size, wdata, ready, resp | err, rd, wr
    localparam vec_t TBL [NV] = '{
        '{1'b0, 2'd0, 32'h000, 1'b0, 3'd2, 32'h0000, 1'b1, 1'b0, 5'h00, 8'd0, 8'd0}, // idle
        '{1'b0, 2'd2, 32'h100, 1'b0, 3'd2, 32'h0000, 1'b1, 1'b0, 5'h00, 8'd0, 8'd0}, // R1 read A
        '{1'b0, 2'd2, 32'h104, 1'b1, 3'd2, 32'h0000, 1'b1, 1'b0, 5'h00, 8'd1, 8'd0}, // R1 read done
        '{1'b0, 2'd0, 32'h000, 1'b0, 3'd2, 32'hAAAA, 1'b0, 1'b0, 5'h00, 8'd1, 8'd0}, // R2 write wait
        '{1'b0, 2'd0, 32'h000, 1'b0, 3'd2, 32'hAAAA, 1'b1, 1'b0, 5'h00, 8'd1, 8'd1}, // R5 stable wdata ok
        '{1'b0, 2'd2, 32'h200, 1'b0, 3'd2, 32'h0000, 1'b1, 1'b0, 5'h00, 8'd1, 8'd1},
        '{1'b0, 2'd2, 32'h204, 1'b1, 3'd2, 32'h0000, 1'b0, 1'b0, 5'h00, 8'd1, 8'd1}, // R3 held addr
        '{1'b0, 2'd2, 32'h204, 1'b1, 3'd2, 32'h0000, 1'b0, 1'b0, 5'h00, 8'd1, 8'd1},
        '{1'b0, 2'd2, 32'h204, 1'b1, 3'd2, 32'h0000, 1'b1, 1'b0, 5'h00, 8'd2, 8'd1},
        '{1'b0, 2'd0, 32'h000, 1'b0, 3'd2, 32'h0055, 1'b1, 1'b0, 5'h00, 8'd2, 8'd2},
        '{1'b0, 2'd2, 32'h300, 1'b0, 3'd2, 32'h0000, 1'b1, 1'b0, 5'h00, 8'd2, 8'd2},
        '{1'b0, 2'd2, 32'h304, 1'b0, 3'd2, 32'h0000, 1'b0, 1'b0, 5'h00, 8'd2, 8'd2},
        '{1'b0, 2'd2, 32'h308, 1'b0, 3'd2, 32'h0000, 1'b1, 1'b0, 5'h01, 8'd3, 8'd2}, // R3 addr moved
        '{1'b0, 2'd0, 32'h000, 1'b0, 3'd2, 32'h0000, 1'b1, 1'b0, 5'h01, 8'd4, 8'd2}, // R8 sticky
        '{1'b1, 2'd0, 32'h000, 1'b0, 3'd2, 32'h0000, 1'b1, 1'b0, 5'h00, 8'd4, 8'd2}, // R8 clear
        '{1'b0, 2'd2, 32'h400, 1'b1, 3'd2, 32'h0000, 1'b1, 1'b0, 5'h00, 8'd4, 8'd2},
        '{1'b0, 2'd2, 32'h404, 1'b0, 3'd2, 32'h0011, 1'b0, 1'b0, 5'h00, 8'd4, 8'd2},
        '{1'b0, 2'd2, 32'h404, 1'b1, 3'd2, 32'h0022, 1'b1, 1'b0, 5'h06, 8'd4, 8'd3}, // R4 R5 with completion
        '{1'b0, 2'd0, 32'h000, 1'b0, 3'd2, 32'h0033, 1'b1, 1'b0, 5'h06, 8'd4, 8'd4},
        '{1'b1, 2'd0, 32'h000, 1'b0, 3'd2, 32'h0000, 1'b0, 1'b0, 5'h10, 8'd4, 8'd4}, // R7 R8 set beats clear
        '{1'b1, 2'd0, 32'h000, 1'b0, 3'd2, 32'h0000, 1'b1, 1'b0, 5'h00, 8'd4, 8'd4},
        '{1'b0, 2'd3, 32'h500, 1'b0, 3'd2, 32'h0000, 1'b1, 1'b0, 5'h08, 8'd4, 8'd4}, // R6 SEQ
        '{1'b0, 2'd0, 32'h000, 1'b0, 3'd2, 32'h0000, 1'b1, 1'b0, 5'h08, 8'd4, 8'd4},
        '{1'b1, 2'd0, 32'h000, 1'b0, 3'd2, 32'h0000, 1'b1, 1'b0, 5'h00, 8'd4, 8'd4},
        '{1'b0, 2'd2, 32'h600, 1'b0, 3'd2, 32'h0000, 1'b1, 1'b0, 5'h00, 8'd4, 8'd4},
        '{1'b0, 2'd0, 32'h000, 1'b0, 3'd2, 32'h0000, 1'b1, 1'b1, 5'h00, 8'd4, 8'd4}, // R2 error resp
        '{1'b0, 2'd2, 32'h700, 1'b1, 3'd2, 32'h0000, 1'b1, 1'b0, 5'h00, 8'd4, 8'd4},
        '{1'b0, 2'd0, 32'h000, 1'b0, 3'd2, 32'h0077, 1'b0, 1'b0, 5'h00, 8'd4, 8'd4},
        '{1'b0, 2'd0, 32'h000, 1'b0, 3'd2, 32'h0077, 1'b1, 1'b0, 5'h00, 8'd4, 8'd5},
        '{1'b0, 2'd2, 32'h800, 1'b0, 3'd2, 32'h0000, 1'b1, 1'b0, 5'h00, 8'd4, 8'd5},
        '{1'b0, 2'd0, 32'h000, 1'b0, 3'd2, 32'h0001, 1'b0, 1'b0, 5'h00, 8'd4, 8'd5}, // R5 read stall
        '{1'b0, 2'd0, 32'h000, 1'b0, 3'd2, 32'h0002, 1'b1, 1'b0, 5'h00, 8'd5, 8'd5}  // R5 no flag on read
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        err_clr;
    logic [1:0]  mon_trans;
    logic [31:0] mon_addr;
    logic        mon_write;
    logic [2:0]  mon_size;
    logic [31:0] mon_wdata;
    logic        mon_ready;
    logic        mon_resp;
    logic [4:0]  err_flags;
    logic [7:0]  rd_done_cnt;
    logic [7:0]  wr_done_cnt;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    bus_phase_monitor u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_clr    (err_clr),
        .mon_trans  (mon_trans),
        .mon_addr   (mon_addr),
        .mon_write  (mon_write),
        .mon_size   (mon_size),
        .mon_wdata  (mon_wdata),
        .mon_ready  (mon_ready),
        .mon_resp   (mon_resp),
        .err_flags  (err_flags),
        .rd_done_cnt(rd_done_cnt),
        .wr_done_cnt(wr_done_cnt)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic [1:0] t, input logic [31:0] a,
                         input logic w, input logic [2:0] s, input logic [31:0] d,
                         input logic r, input logic p);
        err_clr = c; mon_trans = t; mon_addr = a; mon_write = w;
        mon_size = s; mon_wdata = d; mon_ready = r; mon_resp = p;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        drive(0, 2'd0, 0, 0, 3'd2, 0, 1, 0);
        repeat (3) step();
        check("R9 reset flags", 32'(err_flags), 0);
        check("R9 reset rd", 32'(rd_done_cnt), 0);
        check("R9 reset wr", 32'(wr_done_cnt), 0);
        rst_n = 1'b1;

        // Vector table: R1 R2 R3 R4 R5 R6 R7 R8 covered per row comments.
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].clr, TBL[i].tr, TBL[i].addr, TBL[i].wr, TBL[i].sz,
                  TBL[i].wd, TBL[i].rdy, TBL[i].rsp);
            step();
            check($sformatf("row %0d err_flags", i), 32'(err_flags), 32'(TBL[i].e));
            check($sformatf("row %0d rd_done_cnt", i), 32'(rd_done_cnt), 32'(TBL[i].r));
            check($sformatf("row %0d wr_done_cnt", i), 32'(wr_done_cnt), 32'(TBL[i].w));
        end

        // R3: size change while address is held.
        drive(0, 2'd2, 32'h900, 0, 3'd2, 0, 1, 0); step();
        drive(0, 2'd2, 32'h904, 0, 3'd2, 0, 0, 0); step();
        check("R3 no flag before change", 32'(err_flags), 0);
        drive(0, 2'd2, 32'h904, 0, 3'd1, 0, 1, 0); step();
        check("R3 size moved under stall", 32'(err_flags), 32'h01);
        drive(0, 2'd0, 0, 0, 3'd2, 0, 1, 0); step();
        check("R1 reads after size test", 32'(rd_done_cnt), 7);

        // R1: ten back-to-back writes, one per cycle.
        drive(1, 2'd0, 0, 0, 3'd2, 0, 1, 0); step();
        for (int k = 0; k < 10; k++) begin
            drive(0, 2'd2, 32'hA00 + 32'(k * 4), 1, 3'd2, 32'(k), 1, 0);
            step();
        end
        drive(0, 2'd0, 0, 0, 3'd2, 32'h99, 1, 0); step();
        check("R1 pipelined writes", 32'(wr_done_cnt), 15);
        check("R1 pipelined no flags", 32'(err_flags), 0);

        // R9: reset in the middle of a run with a flag set.
        drive(0, 2'd1, 0, 0, 3'd2, 0, 1, 0); step();
        check("R6 BUSY flagged", 32'(err_flags), 32'h08);
        rst_n = 1'b0;
        drive(0, 2'd0, 0, 0, 3'd2, 0, 1, 0);
        repeat (2) step();
        check("R9 mid reset flags", 32'(err_flags), 0);
        check("R9 mid reset rd", 32'(rd_done_cnt), 0);
        check("R9 mid reset wr", 32'(wr_done_cnt), 0);
        rst_n = 1'b1;
        drive(0, 2'd0, 0, 0, 3'd2, 0, 0, 0); step();
        check("R9 phase state cleared, R7 wait flagged", 32'(err_flags), 32'h10);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired R1 actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule